// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

A synchronous memory with two fully independent access ports, A and B. Both ports can read and write any word. Each port has its own clock, enable, byte-lane write strobes, address, write data, synchronous reset and read data. Three things are chosen separately for each port by parameters:

- what the read output shows on a cycle that writes;
- how many register stages the read path has;
- the value the last output stage takes on reset.

A word is `LANES` lanes of `BYTE_W` bits each. `BYTE_W` is 8, or 9 when each lane carries a parity bit. Both ports use the same width.

The port enable is the request qualifier. An enabled cycle with no strobe set is a read. An enabled cycle with any strobe set is a write. The block accepts a request on every enabled edge and has no back-pressure, so no ready signal exists. Read data is valid a fixed number of cycles later, and the consumer must take it in that cycle. When `COMMON_CLK` is set, both ports are expected to be driven from one clock and all array writes are made in that domain. Otherwise each port writes in its own clock domain.

Top module: `dpram_wm`

## Requirements
- R1: A request accepted at a rising edge of a port's clock presents its read word on that port's output after exactly `LAT` rising edges of the same clock, counting the accepting edge. Only the first read stage is gated by the enable. Every later stage takes the value of the stage before it on every edge.
- R2: While a port's enable is low, that port writes nothing, whatever its strobes show. Its first read stage keeps its value.
- R3: In read-first mode (`WM_READ_FIRST`, code 0), an enabled cycle loads the first read stage with the word as it was before that edge, whether or not the cycle writes.
- R4: In write-first mode (`WM_WRITE_FIRST`, code 1), an enabled write loads the first read stage with the updated word. Strobed lanes take the new data and the other lanes keep the stored data.
- R5: In no-change mode (`WM_NO_CHANGE`, code 2), an enabled cycle with any effective strobe leaves the first read stage unchanged. An enabled cycle with no strobe reads the stored word.
- R6: A port's reset, sampled high at an edge of its clock, loads that port's last output stage with `RST_A` or `RST_B`. The reset does not change the stored words or the other port.
- R7: With per-lane writes on (`BWE_x = 1`), strobe bit i writes only bits `[i*BYTE_W +: BYTE_W]` of the word. With per-lane writes off, any set strobe bit writes the whole word.
- R8: A word written through one port is read back by the other port on any later request. A same-edge read of the word on the other port returns the contents from before that edge. The two ports must never write the same word on the same edge under a common clock; the checker flags that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A (and of all array writes when `COMMON_CLK` = 1) |
| rst_a | input | 1 | Synchronous reset of port A's last output stage |
| en_a | input | 1 | Port A request enable |
| we_a | input | LANES | Port A lane write strobes |
| addr_a | input | $clog2(DEPTH) | Port A word address |
| din_a | input | BYTE_W*LANES | Port A write data |
| dout_a | output | BYTE_W*LANES | Port A read data |
| clk_b | input | 1 | Clock of port B |
| rst_b | input | 1 | Synchronous reset of port B's last output stage |
| en_b | input | 1 | Port B request enable |
| we_b | input | LANES | Port B lane write strobes |
| addr_b | input | $clog2(DEPTH) | Port B word address |
| din_b | input | BYTE_W*LANES | Port B write data |
| dout_b | output | BYTE_W*LANES | Port B read data |

## Verification
The assertions check the following on every cycle, per port and per mode:
- a disabled port's first read stage holds;
- in read-first mode, the first stage captures the pre-write word;
- in write-first mode, each strobed lane carries the new data;
- in no-change mode, the first stage holds through writes;
- reset loads the configured value;
- the two ports never write the same word together.

Only the bench scenarios can show the end-to-end properties. These are the exact output latency through deeper pipelines and the contents that accumulate from mixed-lane writes. They also include cross-port read-back of earlier writes and the fact that a reset leaves the stored words intact. The bench checks all of these against a behavioural model on two differently configured instances.

// File: rtl/dpram_wm_pkg.sv
package dpram_wm_pkg;

  // Read-port behaviour on a cycle that also writes
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

endpackage

// File: rtl/dpram_wm_lanes.sv
// Byte-lane strobe qualification and merge of new data over the stored word.
module dpram_wm_lanes #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter bit BWE    = 1'b1,
  localparam int DW    = BYTE_W * LANES
) (
  input  logic             en,
  input  logic [LANES-1:0] we,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    old_word,
  output logic [LANES-1:0] wmask,
  output logic [DW-1:0]    merged
);

  logic any_we;
  assign any_we = |we;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (BWE) begin : g_bw
      assign wmask[i] = en & we[i];
    end else begin : g_word
      assign wmask[i] = en & any_we;
    end
    assign merged[i*BYTE_W +: BYTE_W] = wmask[i] ? din[i*BYTE_W +: BYTE_W]
                                                 : old_word[i*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/dpram_wm_port.sv
// One access port: write-mode selection, gated first read stage,
// free-running later stages and a reset value on the last stage.
module dpram_wm_port
  import dpram_wm_pkg::*;
#(
  parameter int     BYTE_W  = 8,
  parameter int     LANES   = 4,
  parameter bit     BWE     = 1'b1,
  parameter wmode_e MODE    = WM_READ_FIRST,
  parameter int     LAT     = 1,
  parameter logic [BYTE_W*LANES-1:0] RST_VAL = '0,
  localparam int    DW      = BYTE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LANES-1:0] we,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    old_word,
  output logic [LANES-1:0] wmask,
  output logic [DW-1:0]    dout
);

  logic [DW-1:0] merged;
  logic [DW-1:0] nxt;
  logic [DW-1:0] stg [LAT];

  dpram_wm_lanes #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES),
    .BWE    (BWE)
  ) u_lanes (
    .en       (en),
    .we       (we),
    .din      (din),
    .old_word (old_word),
    .wmask    (wmask),
    .merged   (merged)
  );

  always_comb begin
    unique case (MODE)
      WM_WRITE_FIRST: nxt = merged;
      WM_NO_CHANGE:   nxt = (|wmask) ? stg[0] : old_word;
      default:        nxt = old_word;
    endcase
  end

  // Stage 0 is request gated; deeper stages shift every edge; reset wins
  // on the last stage (which is stage 0 itself when LAT is 1).
  always_ff @(posedge clk) begin
    if (en) stg[0] <= nxt;
    for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
    if (rst) stg[LAT-1] <= RST_VAL;
  end

  assign dout = stg[LAT-1];

endmodule

// File: rtl/dpram_wm.sv
// True dual-port RAM, symmetric widths, per-port write mode and read latency.
module dpram_wm
  import dpram_wm_pkg::*;
#(
  parameter int     DEPTH      = 256,
  parameter int     BYTE_W     = 8,
  parameter int     LANES      = 4,
  parameter bit     COMMON_CLK = 1'b1,
  parameter wmode_e MODE_A     = WM_READ_FIRST,
  parameter wmode_e MODE_B     = WM_WRITE_FIRST,
  parameter int     LAT_A      = 1,
  parameter int     LAT_B      = 2,
  parameter bit     BWE_A      = 1'b1,
  parameter bit     BWE_B      = 1'b1,
  parameter logic [BYTE_W*LANES-1:0] RST_A = '0,
  parameter logic [BYTE_W*LANES-1:0] RST_B = '0
) (
  input  logic                       clk_a,
  input  logic                       rst_a,
  input  logic                       en_a,
  input  logic [LANES-1:0]           we_a,
  input  logic [$clog2(DEPTH)-1:0]   addr_a,
  input  logic [BYTE_W*LANES-1:0]    din_a,
  output logic [BYTE_W*LANES-1:0]    dout_a,
  input  logic                       clk_b,
  input  logic                       rst_b,
  input  logic                       en_b,
  input  logic [LANES-1:0]           we_b,
  input  logic [$clog2(DEPTH)-1:0]   addr_b,
  input  logic [BYTE_W*LANES-1:0]    din_b,
  output logic [BYTE_W*LANES-1:0]    dout_b
);

  localparam int DW = BYTE_W * LANES;
  localparam int AW = $clog2(DEPTH);

  if (!(BYTE_W == 8 || BYTE_W == 9) || LAT_A < 1 || LAT_B < 1) begin : g_bad_cfg
    $error("dpram_wm: lane width must be 8 or 9 and latencies at least 1");
  end

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    old_a, old_b;
  logic [LANES-1:0] wmask_a, wmask_b;

  assign old_a = mem[addr_a];
  assign old_b = mem[addr_b];

  dpram_wm_port #(
    .BYTE_W (BYTE_W), .LANES (LANES), .BWE (BWE_A),
    .MODE (MODE_A), .LAT (LAT_A), .RST_VAL (RST_A)
  ) u_port_a (
    .clk (clk_a), .rst (rst_a), .en (en_a), .we (we_a), .din (din_a),
    .old_word (old_a), .wmask (wmask_a), .dout (dout_a)
  );

  dpram_wm_port #(
    .BYTE_W (BYTE_W), .LANES (LANES), .BWE (BWE_B),
    .MODE (MODE_B), .LAT (LAT_B), .RST_VAL (RST_B)
  ) u_port_b (
    .clk (clk_b), .rst (rst_b), .en (en_b), .we (we_b), .din (din_b),
    .old_word (old_b), .wmask (wmask_b), .dout (dout_b)
  );

  if (COMMON_CLK) begin : g_common
    // One write process: port A is applied last on a same-word clash.
    always_ff @(posedge clk_a) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask_b[i]) mem[addr_b][i*BYTE_W +: BYTE_W] <= din_b[i*BYTE_W +: BYTE_W];
        if (wmask_a[i]) mem[addr_a][i*BYTE_W +: BYTE_W] <= din_a[i*BYTE_W +: BYTE_W];
      end
    end
  end else begin : g_indep
    always_ff @(posedge clk_a) begin
      for (int i = 0; i < LANES; i++)
        if (wmask_a[i]) mem[addr_a][i*BYTE_W +: BYTE_W] <= din_a[i*BYTE_W +: BYTE_W];
    end
    always_ff @(posedge clk_b) begin
      for (int i = 0; i < LANES; i++)
        if (wmask_b[i]) mem[addr_b][i*BYTE_W +: BYTE_W] <= din_b[i*BYTE_W +: BYTE_W];
    end
  end

  logic unused_aw;
  assign unused_aw = ^AW;

endmodule

// File: rtl/dpram_wm_chk.sv
module dpram_wm_chk
  import dpram_wm_pkg::*;
#(
  parameter int     BYTE_W     = 8,
  parameter int     LANES      = 4,
  parameter int     AW         = 8,
  parameter bit     COMMON_CLK = 1'b1,
  parameter wmode_e MODE_A     = WM_READ_FIRST,
  parameter wmode_e MODE_B     = WM_WRITE_FIRST,
  parameter logic [BYTE_W*LANES-1:0] RST_A = '0,
  parameter logic [BYTE_W*LANES-1:0] RST_B = '0,
  localparam int    DW         = BYTE_W * LANES
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst_a,
  input logic             rst_b,
  input logic             en_a,
  input logic             en_b,
  input logic [AW-1:0]    addr_a,
  input logic [AW-1:0]    addr_b,
  input logic [DW-1:0]    din_a,
  input logic [DW-1:0]    din_b,
  input logic [LANES-1:0] wmask_a,
  input logic [LANES-1:0] wmask_b,
  input logic [DW-1:0]    old_a,
  input logic [DW-1:0]    old_b,
  input logic [DW-1:0]    first_a,
  input logic [DW-1:0]    first_b,
  input logic [DW-1:0]    dout_a,
  input logic [DW-1:0]    dout_b
);

  // R2: an idle port keeps its first read stage
  a_r2_idle_hold_a: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable(first_a));
  a_r2_idle_hold_b: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable(first_b));

  // R6: reset loads the configured value on the last stage
  a_r6_reset_value_a: assert property (@(posedge clk_a) rst_a |=> dout_a == RST_A);
  a_r6_reset_value_b: assert property (@(posedge clk_b) rst_b |=> dout_b == RST_B);

  if (MODE_A == WM_READ_FIRST) begin : g_rf_a
    a_r3_read_first_a: assert property (@(posedge clk_a) disable iff (rst_a)
      en_a |=> first_a == $past(old_a));
  end
  if (MODE_B == WM_READ_FIRST) begin : g_rf_b
    a_r3_read_first_b: assert property (@(posedge clk_b) disable iff (rst_b)
      en_b |=> first_b == $past(old_b));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (MODE_A == WM_WRITE_FIRST) begin : g_wf_a
      a_r4_write_first_a: assert property (@(posedge clk_a) disable iff (rst_a)
        wmask_a[i] |=> first_a[i*BYTE_W +: BYTE_W] == $past(din_a[i*BYTE_W +: BYTE_W]));
    end
    if (MODE_B == WM_WRITE_FIRST) begin : g_wf_b
      a_r4_write_first_b: assert property (@(posedge clk_b) disable iff (rst_b)
        wmask_b[i] |=> first_b[i*BYTE_W +: BYTE_W] == $past(din_b[i*BYTE_W +: BYTE_W]));
    end
  end

  if (MODE_A == WM_NO_CHANGE) begin : g_nc_a
    a_r5_no_change_a: assert property (@(posedge clk_a) disable iff (rst_a)
      (|wmask_a) |=> $stable(first_a));
  end
  if (MODE_B == WM_NO_CHANGE) begin : g_nc_b
    a_r5_no_change_b: assert property (@(posedge clk_b) disable iff (rst_b)
      (|wmask_b) |=> $stable(first_b));
  end

  if (COMMON_CLK) begin : g_clash
    a_r8_no_same_word_write: assert property (@(posedge clk_a) disable iff (rst_a)
      !((|wmask_a) && (|wmask_b) && (addr_a == addr_b)));
  end

endmodule

bind dpram_wm dpram_wm_chk #(
  .BYTE_W (BYTE_W), .LANES (LANES), .AW (AW), .COMMON_CLK (COMMON_CLK),
  .MODE_A (MODE_A), .MODE_B (MODE_B), .RST_A (RST_A), .RST_B (RST_B)
) u_chk (
  .clk_a (clk_a), .clk_b (clk_b), .rst_a (rst_a), .rst_b (rst_b),
  .en_a (en_a), .en_b (en_b), .addr_a (addr_a), .addr_b (addr_b),
  .din_a (din_a), .din_b (din_b), .wmask_a (wmask_a), .wmask_b (wmask_b),
  .old_a (old_a), .old_b (old_b),
  .first_a (u_port_a.stg[0]), .first_b (u_port_b.stg[0]),
  .dout_a (dout_a), .dout_b (dout_b)
);

// File: tb/dpram_wm_tb.sv
`timescale 1ns/1ps
module dpram_wm_tb;
  import dpram_wm_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_a, rst_b, en_a, en_b;
  logic [3:0]  we_a, we_b;
  logic [7:0]  addr_a, addr_b;
  logic [31:0] din_a, din_b;
  logic [31:0] dout [4];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  // Instance 0: A read-first lat 1, B write-first lat 2, both per-lane
  dpram_wm #(
    .MODE_A (WM_READ_FIRST), .MODE_B (WM_WRITE_FIRST), .LAT_A (1), .LAT_B (2),
    .BWE_A (1'b1), .BWE_B (1'b1), .RST_A (32'hA5A5_0001), .RST_B (32'h5A5A_0002)
  ) u_dut (
    .clk_a (clk), .rst_a (rst_a), .en_a (en_a), .we_a (we_a), .addr_a (addr_a),
    .din_a (din_a), .dout_a (dout[0]),
    .clk_b (clk), .rst_b (rst_b), .en_b (en_b), .we_b (we_b), .addr_b (addr_b),
    .din_b (din_b), .dout_b (dout[1])
  );

  // Instance 1: A no-change lat 3, B write-first lat 1 whole-word writes
  dpram_wm #(
    .MODE_A (WM_NO_CHANGE), .MODE_B (WM_WRITE_FIRST), .LAT_A (3), .LAT_B (1),
    .BWE_A (1'b1), .BWE_B (1'b0), .RST_A (32'hDEAD_0003), .RST_B (32'hBEEF_0004)
  ) u_dut_nc (
    .clk_a (clk), .rst_a (rst_a), .en_a (en_a), .we_a (we_a), .addr_a (addr_a),
    .din_a (din_a), .dout_a (dout[2]),
    .clk_b (clk), .rst_b (rst_b), .en_b (en_b), .we_b (we_b), .addr_b (addr_b),
    .din_b (din_b), .dout_b (dout[3])
  );

  // Reference model: per port p (dut p/2, side p%2). Mode 0 RF, 1 WF, 2 NC.
  int          lat  [4] = '{1, 2, 3, 1};
  int          mode [4] = '{0, 1, 2, 1};
  bit          bwe  [4] = '{1, 1, 1, 0};
  logic [31:0] rstv [4] = '{32'hA5A5_0001, 32'h5A5A_0002, 32'hDEAD_0003, 32'hBEEF_0004};
  string       ptag [4] = '{"R3 R7 R8", "R1 R4 R7 R8", "R1 R2 R5 R7", "R4 R7 R8"};
  logic [31:0] mem_ref [2][256];
  logic [31:0] stv [4][4];
  bit          stk [4][4];
  bit          from_rst [4];

  always @(posedge clk) begin
    logic [3:0] mk [4];
    for (int p = 0; p < 4; p++) begin
      logic        en, rs, kn;
      logic [3:0]  we;
      logic [7:0]  ad;
      logic [31:0] dn, old, mrg, nx;
      en = p[0] ? en_b : en_a;   rs = p[0] ? rst_b : rst_a;
      we = p[0] ? we_b : we_a;   ad = p[0] ? addr_b : addr_a;
      dn = p[0] ? din_b : din_a;
      mk[p] = !en ? 4'h0 : (bwe[p] ? we : ((|we) ? 4'hF : 4'h0));
      old = mem_ref[p/2][ad];
      for (int l = 0; l < 4; l++)
        mrg[l*8 +: 8] = mk[p][l] ? dn[l*8 +: 8] : old[l*8 +: 8];
      kn = 1'b1;
      if (mode[p] == 0) nx = old;
      else if (mode[p] == 1) nx = mrg;
      else if (mk[p] != 0) begin nx = stv[p][0]; kn = stk[p][0]; end
      else nx = old;
      for (int i = lat[p] - 1; i > 0; i--) begin
        stv[p][i] = stv[p][i-1]; stk[p][i] = stk[p][i-1];
      end
      if (en) begin stv[p][0] = nx; stk[p][0] = kn; end
      from_rst[p] = rs;
      if (rs) begin stv[p][lat[p]-1] = rstv[p]; stk[p][lat[p]-1] = 1'b1; end
    end
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 4; l++)
        if (mk[p][l]) begin
          if (p[0]) mem_ref[p/2][addr_b][l*8 +: 8] = din_b[l*8 +: 8];
          else      mem_ref[p/2][addr_a][l*8 +: 8] = din_a[l*8 +: 8];
        end
  end

  task automatic compare_all();
    for (int p = 0; p < 4; p++) begin
      if (stk[p][lat[p]-1]) begin
        checks++;
        if (dout[p] !== stv[p][lat[p]-1]) begin
          errors++;
          $display("FAIL %s port%0d cycle %0d: actual %h expected %h",
                   from_rst[p] ? "R6" : ptag[p], p, cyc, dout[p], stv[p][lat[p]-1]);
        end
      end
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) for (int w = 0; w < 256; w++) mem_ref[d][w] = 'x;
    for (int p = 0; p < 4; p++) for (int i = 0; i < 4; i++) stk[p][i] = 1'b0;
    rst_a = 1; rst_b = 1; en_a = 0; en_b = 0; we_a = 0; we_b = 0;
    addr_a = 0; addr_b = 0; din_a = 0; din_b = 0;
    // Reset state: R6 values on every port
    repeat (3) @(negedge clk);
    compare_all();
    // Fill the low words through both ports so later reads are known
    rst_a = 0; rst_b = 0;
    for (int w = 0; w < 16; w += 2) begin
      @(negedge clk); cyc++; compare_all();
      en_a = 1; we_a = 4'hF; addr_a = 8'(w);   din_a = $urandom;
      en_b = 1; we_b = 4'hF; addr_b = 8'(w+1); din_b = $urandom;
    end
    // Mixed traffic: all modes, lane patterns, idle cycles, resets, cross-port
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); cyc++; compare_all();
      en_a  = ($urandom % 4) != 0;  en_b = ($urandom % 4) != 0;
      we_a  = ($urandom % 2) ? 4'($urandom) : 4'h0;
      we_b  = ($urandom % 2) ? 4'($urandom) : 4'h0;
      addr_a = 8'($urandom % 16);   addr_b = 8'($urandom % 16);
      din_a = $urandom;  din_b = $urandom;
      rst_a = ($urandom % 40) == 0; rst_b = ($urandom % 40) == 0;
      // R8: never let both ports write one word on the same edge
      if (en_a && (|we_a) && en_b && (|we_b) && addr_a == addr_b) we_b = 4'h0;
    end
    en_a = 0; en_b = 0; we_a = 0; we_b = 0; rst_a = 0; rst_b = 0;
    repeat (4) begin @(negedge clk); cyc++; compare_all(); end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule